// File: doc/BRIEF.md
# Time-Slot Power Enable Sequencer

The block switches twelve regulator enable outputs and one clock-output enable in programmed order for four transitions: power-up, power-down, sleep-exit and sleep-entry. A trigger starts a chain of equal-length time slots. Each output carries its own 4-bit slot number for each transition, and it switches at the end of that slot. Power-up and sleep-exit drive outputs high. Power-down and sleep-entry drive them low.

All timing is counted on `tick_i`, a one-cycle strobe that represents 25 us. A step is 10 ticks (250 us) or 40 ticks (1000 us). One slot lasts TIME x step + step/2. The block also owns an active-low system reset. A power-up holds it low until a programmable delay has run after the last slot, and a power-down pulls it low at once. A fault-force input clears every output immediately and aborts any sequence in progress. A `busy_o` level and a one-cycle `done_o` pulse report progress back to the controller that issued the trigger.

Top module: `pwr_slot_sequencer`

## Requirements
- R1: With the slot length L = TIME x step + step/2 ticks (step = 10 ticks when `step_sel_i`=0, 40 ticks when 1), an output with slot code k switches on the k x L-th tick after the clock edge that accepts the trigger.
- R2: Power-up and sleep-exit take TIME from `up_time_i`. Power-down and sleep-entry take TIME from `dn_time_i`.
- R3: An output whose slot code is 0 for the running sequence keeps its level.
- R4: `seq_sel_i` encodes 0 = power-up, 1 = power-down, 2 = sleep-exit, 3 = sleep-entry. Codes 0 and 2 drive mapped outputs high, and codes 1 and 3 drive them low.
- R5: The clock-output enable is sequenced as a thirteenth channel. Its codes sit in bits [51:48] of each code vector, and channel c of `en_o` uses bits [4c+3:4c].
- R6: During power-up, `rst_no` stays low until D ticks after the last slot ends, then goes high. D is 4 x 2^n for codes n = 0..7 and 40 x 2^(n-8) for codes n = 8..15.
- R7: An accepted power-up or power-down trigger drives `rst_no` low in the cycle after the accepting edge. Sleep sequences leave it unchanged.
- R8: While `force_off_i` is high, `en_o`, `clk_en_o` and `rst_no` are low in the same cycle. The running sequence is aborted, triggers are not accepted, and the cleared levels remain after the force is removed.
- R9: A trigger that arrives while `busy_o` is high is ignored.
- R10: `busy_o` is high while a sequence runs. `done_o` is a one-cycle pulse at the edge of the last slot end, or at the edge of the reset release for power-up.
- R11: A sequence ends at the highest slot code used by any channel. When no channel is mapped, a non-power-up sequence raises `done_o` at the accepting edge, and a power-up sequence runs only the reset delay.
- R12: Slot and reset-delay counters advance only on cycles where `tick_i` is high.
- R13: After reset, all enables, the clock enable, `rst_no`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 25 us time-base strobe |
| start_i | input | 1 | Sequence trigger |
| seq_sel_i | input | 2 | Sequence select (R4 encoding) |
| force_off_i | input | 1 | Fault force: all outputs low |
| step_sel_i | input | 1 | Step size: 0 = 10 ticks, 1 = 40 ticks |
| up_time_i | input | 8 | Slot TIME for rising sequences |
| dn_time_i | input | 8 | Slot TIME for falling sequences |
| rst_dly_i | input | 4 | Reset release delay code |
| up_codes_i | input | 52 | Power-up slot codes, 4 bits per channel |
| dn_codes_i | input | 52 | Power-down slot codes |
| sx_codes_i | input | 52 | Sleep-exit slot codes |
| sn_codes_i | input | 52 | Sleep-entry slot codes |
| en_o | output | 12 | Enable outputs |
| clk_en_o | output | 1 | Clock-output enable |
| rst_no | output | 1 | Active-low system reset |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result is registered once behind the accepting edge. An output with code k, and `done_o` for the last slot, both change on edge k x L after the accepting edge. Power-up adds D further edges for the reset release. The reset assertion of R7 is visible one edge after acceptance, while the force clear of R8 acts combinationally in the same cycle. The bench counts edges from the accepting edge and samples on falling edges, so each check lands on cycle k x L (or k x L + D) and on the cycle just before it. The table vectors compare the measured latency with a value precomputed from the formulas. Directed cases probe the cycles around each switch, as well as the effects of forcing, tick gating and ignored triggers.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [1:0] {
    SEQ_PWR_UP    = 2'd0,
    SEQ_PWR_DN    = 2'd1,
    SEQ_SLP_EXIT  = 2'd2,
    SEQ_SLP_ENTRY = 2'd3
  } seq_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_RDLY = 2'd2
  } seq_state_e;

  function automatic logic is_rising(seq_kind_e k);
    return (k == SEQ_PWR_UP) || (k == SEQ_SLP_EXIT);
  endfunction
endpackage

// File: rtl/pseq_slot_timer.sv
module pseq_slot_timer #(
  parameter int CNT_W  = 16,
  parameter int TIME_W = 8,
  parameter int STEP_S = 10,
  parameter int STEP_L = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              step_sel_i,
  output logic              slot_end_o
);
  logic [CNT_W-1:0] step_w, len_q, cnt_q;

  always_comb step_w = step_sel_i ? CNT_W'(STEP_L) : CNT_W'(STEP_S);

  assign slot_end_o = run_i && tick_i && (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= CNT_W'(1);
      cnt_q <= '0;
    end else if (load_i) begin
      len_q <= CNT_W'(time_i) * step_w + (step_w >> 1);
      cnt_q <= '0;
    end else if (run_i && tick_i) begin
      cnt_q <= slot_end_o ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_in_slot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_q));
  assert_hold_no_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pseq_rst_timer.sv
module pseq_rst_timer #(
  parameter int CNT_W  = 16,
  parameter int UNIT_S = 4,
  parameter int UNIT_L = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [3:0] code_i,
  output logic       expire_o
);
  logic [CNT_W-1:0] dly_q, cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == dly_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= CNT_W'(1);
      cnt_q <= '0;
    end else if (load_i) begin
      dly_q <= code_i[3] ? (CNT_W'(UNIT_L) << code_i[2:0])
                         : (CNT_W'(UNIT_S) << code_i[2:0]);
      cnt_q <= '0;
    end else if (run_i && tick_i) begin
      cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
    end
  end

  assert_dly_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < dly_q));
endmodule

// File: rtl/pseq_chan.sv
module pseq_chan #(
  parameter int SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              force_i,
  input  logic              fire_i,
  input  logic [SLOT_W-1:0] slot_idx_i,
  input  logic [SLOT_W-1:0] code_i,
  input  logic              rising_i,
  output logic              lvl_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          lvl_q <= 1'b0;
    else if (force_i)                                     lvl_q <= 1'b0;
    else if (fire_i && code_i != '0 && code_i == slot_idx_i) lvl_q <= rising_i;
  end

  assign lvl_o = lvl_q;

  assert_only_on_slot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire_i && !force_i) |=> $stable(lvl_q));
  assert_unmapped_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == '0 && !force_i) |=> $stable(lvl_q));
  assert_force_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> !lvl_q);
endmodule

// File: rtl/pwr_slot_sequencer.sv
module pwr_slot_sequencer
  import pseq_pkg::*;
#(
  parameter int NEN     = 12,
  parameter int SLOT_W  = 4,
  parameter int TIME_W  = 8,
  parameter int CNT_W   = 16,
  parameter int STEP_S  = 10,
  parameter int STEP_L  = 40,
  parameter int RDLY_S  = 4,
  parameter int RDLY_L  = 40,
  localparam int NCH     = NEN + 1,
  localparam int CODES_W = NCH * SLOT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [1:0]         seq_sel_i,
  input  logic               force_off_i,
  input  logic               step_sel_i,
  input  logic [TIME_W-1:0]  up_time_i,
  input  logic [TIME_W-1:0]  dn_time_i,
  input  logic [3:0]         rst_dly_i,
  input  logic [CODES_W-1:0] up_codes_i,
  input  logic [CODES_W-1:0] dn_codes_i,
  input  logic [CODES_W-1:0] sx_codes_i,
  input  logic [CODES_W-1:0] sn_codes_i,
  output logic [NEN-1:0]     en_o,
  output logic               clk_en_o,
  output logic               rst_no,
  output logic               busy_o,
  output logic               done_o
);
  seq_kind_e         new_kind, seq_q;
  seq_state_e        st_q;
  logic [SLOT_W-1:0] slot_q, last_q, max_new;
  logic [CODES_W-1:0] new_codes, act_codes;
  logic              rst_q, done_q, accept, slot_end, rdly_load, rdly_exp, act_rising;
  logic [NCH-1:0]    lvl;

  assign new_kind   = seq_kind_e'(seq_sel_i);
  assign accept     = start_i && (st_q == ST_IDLE) && !force_off_i;
  assign act_rising = is_rising(seq_q);

  always_comb begin
    unique case (new_kind)
      SEQ_PWR_UP:   new_codes = up_codes_i;
      SEQ_PWR_DN:   new_codes = dn_codes_i;
      SEQ_SLP_EXIT: new_codes = sx_codes_i;
      default:      new_codes = sn_codes_i;
    endcase
    unique case (seq_q)
      SEQ_PWR_UP:   act_codes = up_codes_i;
      SEQ_PWR_DN:   act_codes = dn_codes_i;
      SEQ_SLP_EXIT: act_codes = sx_codes_i;
      default:      act_codes = sn_codes_i;
    endcase
  end

  always_comb begin
    max_new = '0;
    for (int c = 0; c < NCH; c++)
      if (new_codes[c*SLOT_W +: SLOT_W] > max_new) max_new = new_codes[c*SLOT_W +: SLOT_W];
  end

  pseq_slot_timer #(.CNT_W(CNT_W), .TIME_W(TIME_W), .STEP_S(STEP_S), .STEP_L(STEP_L)) u_slot (
    .clk_i, .rst_ni,
    .load_i     (accept),
    .run_i      (st_q == ST_SLOT && !force_off_i),
    .tick_i,
    .time_i     (is_rising(new_kind) ? up_time_i : dn_time_i),
    .step_sel_i,
    .slot_end_o (slot_end)
  );

  assign rdly_load = (accept && new_kind == SEQ_PWR_UP && max_new == '0) ||
                     (slot_end && slot_q == last_q && seq_q == SEQ_PWR_UP);

  pseq_rst_timer #(.CNT_W(CNT_W), .UNIT_S(RDLY_S), .UNIT_L(RDLY_L)) u_rdly (
    .clk_i, .rst_ni,
    .load_i   (rdly_load),
    .run_i    (st_q == ST_RDLY && !force_off_i),
    .tick_i,
    .code_i   (rst_dly_i),
    .expire_o (rdly_exp)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pseq_chan #(.SLOT_W(SLOT_W)) u_ch (
      .clk_i, .rst_ni,
      .force_i    (force_off_i),
      .fire_i     (slot_end),
      .slot_idx_i (slot_q),
      .code_i     (act_codes[c*SLOT_W +: SLOT_W]),
      .rising_i   (act_rising),
      .lvl_o      (lvl[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      seq_q  <= SEQ_PWR_UP;
      slot_q <= '0;
      last_q <= '0;
      rst_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (force_off_i) begin
        st_q  <= ST_IDLE;
        rst_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (start_i) begin
            seq_q  <= new_kind;
            last_q <= max_new;
            slot_q <= SLOT_W'(1);
            if (new_kind == SEQ_PWR_UP || new_kind == SEQ_PWR_DN) rst_q <= 1'b0;
            if (max_new != '0)                st_q   <= ST_SLOT;
            else if (new_kind == SEQ_PWR_UP)  st_q   <= ST_RDLY;
            else                              done_q <= 1'b1;
          end
          ST_SLOT: if (slot_end) begin
            if (slot_q == last_q) begin
              if (seq_q == SEQ_PWR_UP) st_q <= ST_RDLY;
              else begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
          ST_RDLY: if (rdly_exp) begin
            rst_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign en_o     = lvl[NEN-1:0] & ~{NEN{force_off_i}};
  assign clk_en_o = lvl[NEN] & ~force_off_i;
  assign rst_no   = rst_q & ~force_off_i;
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;

  assert_busy_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !force_off_i) |=> ($stable(seq_q) && $stable(last_q)));
  assert_pwr_rst_assert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (new_kind == SEQ_PWR_DN || new_kind == SEQ_PWR_UP)) |=> !rst_no);
  assert_up_rst_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && seq_q == SEQ_PWR_UP) |-> !rst_no);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_slot_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLOT) |-> (slot_q <= last_q && slot_q != '0));
  assert_force_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> (!busy_o && !done_o));
endmodule

// File: tb/test_pwr_slot_sequencer.sv
module test_pwr_slot_sequencer;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        tick = 1'b1, start = 1'b0, force_off = 1'b0, step_sel = 1'b0;
  logic [1:0]  seq_sel = 2'd0;
  logic [7:0]  up_time = '0, dn_time = '0;
  logic [3:0]  rst_dly = '0;
  logic [51:0] up_codes = '0, dn_codes = '0, sx_codes = '0, sn_codes = '0;
  logic [11:0] en;
  logic        clk_en, rst_n_out, busy, done;
  int checks = 0, failures = 0, n_cyc = 0;

  always #4 clk = ~clk;

  pwr_slot_sequencer i_pwr_slot_sequencer (
    .clk_i(clk), .rst_ni, .tick_i(tick), .start_i(start), .seq_sel_i(seq_sel),
    .force_off_i(force_off), .step_sel_i(step_sel), .up_time_i(up_time),
    .dn_time_i(dn_time), .rst_dly_i(rst_dly), .up_codes_i(up_codes),
    .dn_codes_i(dn_codes), .sx_codes_i(sx_codes), .sn_codes_i(sn_codes),
    .en_o(en), .clk_en_o(clk_en), .rst_no(rst_n_out), .busy_o(busy), .done_o(done)
  );

  typedef struct packed {
    logic [1:0]  sq;
    logic [7:0]  ut;
    logic [7:0]  dt;
    logic        stp;
    logic [3:0]  ca;   // channel 0
    logic [3:0]  cb;   // channel 5
    logic [3:0]  dly;
    logic [15:0] exp_n;
    logic [11:0] exp_en;
    logic        exp_rst;
  } vec_t;

  // exp_n = last_code*L (+D for power-up), L = TIME*step + step/2
  localparam vec_t VECS [6] = '{
    '{2'd0, 8'd0, 8'd9, 1'b0, 4'd1, 4'd3, 4'd0, 16'd19,  12'h021, 1'b1},
    '{2'd1, 8'd7, 8'd1, 1'b0, 4'd2, 4'd0, 4'd0, 16'd30,  12'h020, 1'b0},
    '{2'd2, 8'd2, 8'd0, 1'b1, 4'd1, 4'd0, 4'd0, 16'd100, 12'h021, 1'b0},
    '{2'd3, 8'd5, 8'd0, 1'b1, 4'd4, 4'd4, 4'd0, 16'd80,  12'h000, 1'b0},
    '{2'd0, 8'd0, 8'd3, 1'b1, 4'd2, 4'd0, 4'd9, 16'd120, 12'h001, 1'b1},
    '{2'd3, 8'd0, 8'd0, 1'b0, 4'd0, 4'd0, 4'd0, 16'd0,   12'h001, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_codes();
    up_codes = '0; dn_codes = '0; sx_codes = '0; sn_codes = '0;
  endtask

  task automatic set_code(input logic [1:0] sq, input int ch, input logic [3:0] code);
    case (sq)
      2'd0: up_codes[ch*4 +: 4] = code;
      2'd1: dn_codes[ch*4 +: 4] = code;
      2'd2: sx_codes[ch*4 +: 4] = code;
      default: sn_codes[ch*4 +: 4] = code;
    endcase
  endtask

  task automatic kick(input logic [1:0] sq);
    @(negedge clk);
    seq_sel = sq; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; n_cyc = 0;
  endtask

  task automatic step_to(input int k);
    while (n_cyc < k) begin @(negedge clk); n_cyc++; end
  endtask

  task automatic wait_done();
    while (!done && n_cyc < 30000) begin @(negedge clk); n_cyc++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(en == 0 && !clk_en, "R13 enables after reset", int'(en), 0);
    chk(!rst_n_out && !busy && !done, "R13 rst/busy/done after reset", int'({rst_n_out, busy, done}), 0);
    rst_ni = 1'b1;

    // table: R1 R2 R4 R6 R11
    foreach (VECS[i]) begin
      clear_codes();
      up_time = VECS[i].ut; dn_time = VECS[i].dt; step_sel = VECS[i].stp; rst_dly = VECS[i].dly;
      set_code(VECS[i].sq, 0, VECS[i].ca);
      set_code(VECS[i].sq, 5, VECS[i].cb);
      kick(VECS[i].sq);
      wait_done();
      chk(n_cyc == VECS[i].exp_n, "R1/R2 done latency", n_cyc, int'(VECS[i].exp_n));
      chk(en == VECS[i].exp_en, "R4 enable pattern", int'(en), int'(VECS[i].exp_en));
      chk(rst_n_out == VECS[i].exp_rst, "R6 reset level at end", int'(rst_n_out), int'(VECS[i].exp_rst));
      @(negedge clk);
      chk(!done, "R10 done single cycle", int'(done), 0);
    end

    // R5 / R3: clock channel code 2 in power-up, L=5, D=4
    clear_codes(); up_time = 0; step_sel = 0; rst_dly = 0;
    set_code(2'd0, 12, 4'd2);
    kick(2'd0);
    step_to(9);
    chk(!clk_en, "R5 clk_en before slot 2", int'(clk_en), 0);
    step_to(10);
    chk(clk_en, "R5 clk_en at slot 2 end", int'(clk_en), 1);
    chk(en == 12'h001, "R3 unmapped channels hold", int'(en), 1);
    wait_done();
    chk(n_cyc == 14, "R6 release after delay", n_cyc, 14);

    // R7 / R10: power-down with clock channel code 1, L=5
    clear_codes(); dn_time = 0;
    set_code(2'd1, 12, 4'd1);
    kick(2'd1);
    chk(!rst_n_out, "R7 reset asserted after down trigger", int'(rst_n_out), 0);
    step_to(2);
    chk(busy, "R10 busy during sequence", int'(busy), 1);
    step_to(4);
    chk(clk_en && !done, "R5 clk_en before down slot end", int'({clk_en, done}), 2);
    step_to(5);
    chk(!clk_en && done, "R10 done with last slot", int'({clk_en, done}), 1);

    // R9: second trigger while busy
    clear_codes(); up_time = 0; rst_dly = 0;
    set_code(2'd0, 1, 4'd3);
    set_code(2'd1, 0, 4'd1);
    kick(2'd0);
    step_to(3);
    seq_sel = 2'd1; start = 1'b1;
    @(negedge clk); n_cyc++; start = 1'b0;
    wait_done();
    chk(n_cyc == 19, "R9 busy trigger ignored latency", n_cyc, 19);
    chk(en == 12'h003, "R9 enables unaffected", int'(en), 3);

    // R12: no ticks, no progress
    clear_codes(); dn_time = 0; step_sel = 0;
    set_code(2'd3, 1, 4'd1);
    tick = 1'b0;
    kick(2'd3);
    step_to(20);
    chk(busy && en == 12'h003, "R12 stalled without tick", int'(en), 3);
    tick = 1'b1;
    wait_done();
    chk(n_cyc == 25, "R12 resumes on tick", n_cyc, 25);
    chk(en == 12'h001, "R12 channel lowered", int'(en), 1);

    // R8: force mid power-up
    clear_codes(); up_time = 0;
    set_code(2'd0, 2, 4'd2);
    kick(2'd0);
    step_to(3);
    force_off = 1'b1;
    #1;
    chk(en == 0 && !clk_en && !rst_n_out, "R8 immediate clear", int'(en), 0);
    @(negedge clk);
    chk(!busy, "R8 sequence aborted", int'(busy), 0);
    seq_sel = 2'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R8 trigger blocked under force", int'({busy, done}), 0);
    force_off = 1'b0;
    #1;
    chk(en == 0, "R8 levels stay cleared", int'(en), 0);

    // R11 / R6: empty power-up, delay code 1 -> 8 ticks
    clear_codes(); rst_dly = 4'd1;
    kick(2'd0);
    step_to(7);
    chk(!rst_n_out, "R6 reset held before delay", int'(rst_n_out), 0);
    step_to(8);
    chk(rst_n_out && done, "R11 empty up runs delay only", int'({rst_n_out, done}), 3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule